// File: doc/BRIEF.md
# Fault Address Capture Register

This block is a 64-bit system register that holds the physical address of an access that ended in an external abort, together with the security-space tag of that access. A capture strobe from the memory system loads the register. It aligns the address down to a naturally aligned fault granule of 2^GRANULE_LOG2 bytes and drops address bits that the selected physical-address width does not support. A valid flag records that the register holds a meaningful value. While the flag is low, every read returns zero.

Software reads and writes the register through an access port that gives the current privilege level. The block checks privilege on every request, with a fixed priority that depends on the level. The request either completes, raises an undefined-instruction flag, or raises a trap request that carries the target level and syndrome class 0x18. Taking the exception and recording the syndrome happen elsewhere.

Both the capture strobe and the access port accept a beat in every cycle that its valid is high. There is no ready signal and no back-pressure. A producer never waits, and a beat offered on a cycle is consumed in that cycle. Read data and the access verdict are combinational outputs of the same cycle. Stored values change on the next rising clock edge.

Top module: `fault_addr_reg`

## Requirements
- R1: After reset the valid flag is low and a read at level 3 returns zero.
- R2: On `cap_valid`, the address is aligned down by clearing its low GRANULE_LOG2 bits (default 6). `cap_ns` goes to bit 63 and `cap_nse` to bit 62, and the valid flag is set. A read in the next cycle returns this word.
- R3: Bits 61:56 always read zero. The width selector `cfg_pa_width` controls which upper address bits are kept, both on capture and on write:
  - 0: 48-bit width. Bits 55:48 are cleared.
  - 1: 52-bit width. Bits 55:52 are cleared.
  - 2 or 3: 56-bit width. All of bits 55:0 are kept.
- R4: With REALM_EN=1 (default), the tag pair is stored as given: NS in bit 63 and NSE in bit 62. With REALM_EN=0, NSE is stored as 0, and NS is stored only when `cfg_el3_present` is 1.
- R5: Any access from level 0 (`acc_el`=0) raises `undef` and no trap.
- R6: An access from level 1 traps to level 2 (`trap_el`=2, `trap_ec`=0x18) when both `cfg_el2_en` and `cfg_nv` are 1. In every other case it raises `undef`.
- R7: An access from level 2 is decided by `cfg_el3_present` and `cfg_el3_acc_en`:
  - If level 3 is present and its access enable is 0, and `cfg_halted` and `cfg_sdd` are both 1, the access raises `undef`.
  - If level 3 is present and its access enable is 0 in any other case, the access traps to level 3 (`trap_el`=3, `trap_ec`=0x18).
- R8: An access from level 2 that R7 does not stop, and any access from level 3, completes normally. A read returns the stored word. A write stores `acc_wdata` with the R3/R4 masks (no granule alignment) and sets the valid flag.
- R9: A write that traps or is undefined leaves the register unchanged. A denied read returns zero.
- R10: When a capture and a permitted write fall in the same cycle, the capture value is stored and the write is dropped.
- R11: `undef` and `trap` are mutually exclusive. They are zero whenever `acc_valid` is low. `trap_el` and `trap_ec` are zero when no trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_valid | input | 1 | Fault capture strobe |
| cap_addr | input | 56 | Aborting physical address |
| cap_ns | input | 1 | Security tag NS bit of the aborting access |
| cap_nse | input | 1 | Security tag NSE bit of the aborting access |
| acc_valid | input | 1 | Software access request |
| acc_el | input | 2 | Current privilege level 0..3 |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 64 | Write data |
| cfg_nv | input | 1 | Nested-virtualisation enable |
| cfg_el2_en | input | 1 | Level 2 enabled |
| cfg_el3_present | input | 1 | Level 3 exists |
| cfg_el3_acc_en | input | 1 | Level-3 access enable for level-2 accesses |
| cfg_halted | input | 1 | Core halted in debug |
| cfg_sdd | input | 1 | Secure debug disabled |
| cfg_pa_width | input | 2 | Physical-address width select (0:48, 1:52, 2/3:56) |
| rd_data | output | 64 | Read data (same cycle) |
| undef | output | 1 | Undefined-instruction flag (same cycle) |
| trap | output | 1 | Trap request (same cycle) |
| trap_el | output | 2 | Trap target level |
| trap_ec | output | 6 | Trap syndrome class |

## Verification
The verdict outputs (`undef`, `trap`, `trap_el`, `trap_ec`) and `rd_data` are combinational, so they are due in the same cycle as the request. The bench drives each request on a falling edge and samples 1 ns later, before the next rising edge. Captures and writes take effect at the next rising edge. Every stored value is therefore checked by a level-3 read issued on the following falling edge. For a denied or colliding write, that same read shows whether the rising edge left the register alone.

// File: rtl/fault_addr_pkg.sv
package fault_addr_pkg;
  localparam int unsigned REG_W = 64;
  localparam int unsigned PA_W  = 56;
  localparam int unsigned EC_W  = 6;
  localparam logic [EC_W-1:0] EC_SYSREG = 6'h18;

  typedef enum logic [1:0] {LVL0 = 2'd0, LVL1 = 2'd1, LVL2 = 2'd2, LVL3 = 2'd3} lvl_e;

  typedef struct packed {
    logic undef;
    logic trap;
    lvl_e tgt;
  } verdict_t;
endpackage

// File: rtl/fault_addr_access.sv
module fault_addr_access
  import fault_addr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     acc_valid,
  input  lvl_e     acc_el,
  input  logic     cfg_nv,
  input  logic     cfg_el2_en,
  input  logic     cfg_el3_present,
  input  logic     cfg_el3_acc_en,
  input  logic     cfg_halted,
  input  logic     cfg_sdd,
  output verdict_t verdict
);
  always_comb begin
    verdict = '0;
    if (acc_valid) begin
      unique case (acc_el)
        LVL0: verdict.undef = 1'b1;
        LVL1: begin
          if (cfg_el2_en && cfg_nv) begin
            verdict.trap = 1'b1;
            verdict.tgt  = LVL2;
          end else begin
            verdict.undef = 1'b1;
          end
        end
        LVL2: begin
          if (cfg_el3_present && !cfg_el3_acc_en) begin
            if (cfg_halted && cfg_sdd) begin
              verdict.undef = 1'b1;
            end else begin
              verdict.trap = 1'b1;
              verdict.tgt  = LVL3;
            end
          end
        end
        default: ;
      endcase
    end
  end

  a_r5_el0_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_el == LVL0) |-> (verdict.undef && !verdict.trap));
  a_r8_el3_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_el == LVL3) |-> (!verdict.undef && !verdict.trap));
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(verdict.undef && verdict.trap));
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!verdict.undef && !verdict.trap));
endmodule

// File: rtl/fault_addr_fmt.sv
module fault_addr_fmt
  import fault_addr_pkg::*;
#(
  parameter int unsigned ALIGN_LOG2 = 0,
  parameter bit          REALM_EN   = 1'b1
) (
  input  logic [PA_W-1:0]  pa,
  input  logic             ns,
  input  logic             nse,
  input  logic [1:0]       pa_width,
  input  logic             el3_present,
  output logic [REG_W-1:0] word
);
  localparam logic [PA_W-1:0] ALIGN_MASK = ~((PA_W'(1) << ALIGN_LOG2) - PA_W'(1));

  logic [PA_W-1:0] pa_al;
  logic            ns_k;
  logic            nse_k;

  generate
    if (REALM_EN) begin : g_realm
      assign nse_k = nse;
      assign ns_k  = ns;
    end else begin : g_norealm
      assign nse_k = 1'b0;
      assign ns_k  = ns & el3_present;
    end
  endgenerate

  always_comb begin
    pa_al = pa & ALIGN_MASK;
    if (!pa_width[1]) pa_al[55:52] = 4'h0;
    if (pa_width == 2'd0) pa_al[51:48] = 4'h0;
    word = {ns_k, nse_k, 6'b0, pa_al};
  end
endmodule

// File: rtl/fault_addr_reg.sv
module fault_addr_reg
  import fault_addr_pkg::*;
#(
  parameter int unsigned GRANULE_LOG2 = 6,
  parameter bit          REALM_EN     = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_valid,
  input  logic [55:0] cap_addr,
  input  logic        cap_ns,
  input  logic        cap_nse,
  input  logic        acc_valid,
  input  logic [1:0]  acc_el,
  input  logic        acc_write,
  input  logic [63:0] acc_wdata,
  input  logic        cfg_nv,
  input  logic        cfg_el2_en,
  input  logic        cfg_el3_present,
  input  logic        cfg_el3_acc_en,
  input  logic        cfg_halted,
  input  logic        cfg_sdd,
  input  logic [1:0]  cfg_pa_width,
  output logic [63:0] rd_data,
  output logic        undef,
  output logic        trap,
  output logic [1:0]  trap_el,
  output logic [5:0]  trap_ec
);
  verdict_t         verdict;
  logic [REG_W-1:0] cap_word;
  logic [REG_W-1:0] wr_word;
  logic [REG_W-1:0] store_q;
  logic             vld_q;
  logic             granted;
  logic             wr_take;

  fault_addr_access u_access (
    .clk             (clk),
    .rst_n           (rst_n),
    .acc_valid       (acc_valid),
    .acc_el          (lvl_e'(acc_el)),
    .cfg_nv          (cfg_nv),
    .cfg_el2_en      (cfg_el2_en),
    .cfg_el3_present (cfg_el3_present),
    .cfg_el3_acc_en  (cfg_el3_acc_en),
    .cfg_halted      (cfg_halted),
    .cfg_sdd         (cfg_sdd),
    .verdict         (verdict)
  );

  fault_addr_fmt #(.ALIGN_LOG2(GRANULE_LOG2), .REALM_EN(REALM_EN)) u_cap_fmt (
    .pa          (cap_addr),
    .ns          (cap_ns),
    .nse         (cap_nse),
    .pa_width    (cfg_pa_width),
    .el3_present (cfg_el3_present),
    .word        (cap_word)
  );

  fault_addr_fmt #(.ALIGN_LOG2(0), .REALM_EN(REALM_EN)) u_wr_fmt (
    .pa          (acc_wdata[PA_W-1:0]),
    .ns          (acc_wdata[63]),
    .nse         (acc_wdata[62]),
    .pa_width    (cfg_pa_width),
    .el3_present (cfg_el3_present),
    .word        (wr_word)
  );

  assign granted = acc_valid && !verdict.undef && !verdict.trap;
  assign wr_take = granted && acc_write && !cap_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
      vld_q   <= 1'b0;
    end else if (cap_valid) begin
      store_q <= cap_word;
      vld_q   <= 1'b1;
    end else if (wr_take) begin
      store_q <= wr_word;
      vld_q   <= 1'b1;
    end
  end

  assign rd_data = (granted && !acc_write && vld_q) ? store_q : '0;
  assign undef   = verdict.undef;
  assign trap    = verdict.trap;
  assign trap_el = verdict.trap ? verdict.tgt : 2'd0;
  assign trap_ec = verdict.trap ? EC_SYSREG : '0;

  a_r3_res0: assert property (@(posedge clk) disable iff (!rst_n)
    store_q[61:56] == 6'b0);
  a_r1_invalid_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> rd_data == '0);
  a_r2_capture_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |=> vld_q);
  a_r9_denied_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && (undef || trap) && !cap_valid) |=> $stable(store_q));
  a_r6_trap_class: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (trap_ec == 6'h18 && trap_el >= 2'd2));
endmodule

// File: tb/fault_addr_reg_tb.sv
module fault_addr_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_valid = 1'b0;
  logic [55:0] cap_addr = '0;
  logic        cap_ns = 1'b0, cap_nse = 1'b0;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_el = '0;
  logic        acc_write = 1'b0;
  logic [63:0] acc_wdata = '0;
  logic        cfg_nv = 0, cfg_el2_en = 0, cfg_el3_present = 1, cfg_el3_acc_en = 1;
  logic        cfg_halted = 0, cfg_sdd = 0;
  logic [1:0]  cfg_pa_width = 2'd2;
  logic [63:0] rd_data;
  logic        undef, trap;
  logic [1:0]  trap_el;
  logic [5:0]  trap_ec;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fault_addr_reg u_dut (.*);

  // {el[1:0], nv, el2_en, el3_present, el3_acc_en, halted, sdd} -> {undef, trap, trap_el[1:0]}
  localparam logic [11:0] VEC [10] = '{
    {8'b00_111111, 4'b1000},
    {8'b01_110000, 4'b0110},
    {8'b01_100000, 4'b1000},
    {8'b01_010000, 4'b1000},
    {8'b10_001000, 4'b0111},
    {8'b10_001011, 4'b1000},
    {8'b10_001010, 4'b0111},
    {8'b10_001100, 4'b0000},
    {8'b10_000011, 4'b0000},
    {8'b11_111011, 4'b0000}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] expw(input logic [55:0] a, input logic ns, input logic nse,
                                       input logic [1:0] w, input int al);
    logic [55:0] m;
    m = a;
    for (int i = 0; i < al; i++) m[i] = 1'b0;
    if (w == 2'd0) m[55:48] = 8'h0;
    if (w == 2'd1) m[55:52] = 4'h0;
    return {ns, nse, 6'b0, m};
  endfunction

  task automatic access(input logic [1:0] el, input logic wr, input logic [63:0] wd);
    @(negedge clk);
    acc_valid = 1'b1; acc_el = el; acc_write = wr; acc_wdata = wd;
    #1;
  endtask

  task automatic release_acc();
    @(posedge clk); #1;
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic read3(output logic [63:0] v);
    access(2'd3, 1'b0, '0);
    v = rd_data;
    release_acc();
  endtask

  task automatic capture(input logic [55:0] a, input logic ns, input logic nse);
    @(negedge clk);
    cap_valid = 1'b1; cap_addr = a; cap_ns = ns; cap_nse = nse;
    @(posedge clk); #1;
    cap_valid = 1'b0;
  endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] v, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    read3(v);
    check(v == 64'h0, "R1 reset read", v, 64'h0);

    // R11: idle request shows no verdict even at level 0
    @(negedge clk); acc_el = 2'd0; #1;
    check(!undef && !trap && trap_el == 0 && trap_ec == 0, "R11 idle quiet",
          {undef, trap, trap_el, trap_ec}, 0);

    // R5 R6 R7 R8: verdict table
    foreach (VEC[i]) begin
      logic [11:0] t;
      t = VEC[i];
      cfg_nv = t[9]; cfg_el2_en = t[8]; cfg_el3_present = t[7];
      cfg_el3_acc_en = t[6]; cfg_halted = t[5]; cfg_sdd = t[4];
      access(t[11:10], 1'b0, '0);
      e = {52'h0, t[3], t[2], t[1:0], (t[2] ? 6'h18 : 6'h0)};
      v = {52'h0, undef, trap, trap_el, trap_ec};
      check(v[9:0] == e[9:0], $sformatf("R5/R6/R7 verdict vec%0d", i), v, e);
      release_acc();
    end
    cfg_nv = 0; cfg_el2_en = 1; cfg_el3_present = 1; cfg_el3_acc_en = 1;
    cfg_halted = 0; cfg_sdd = 0;

    // R2 R4: capture 56-bit, granule aligned, tags kept
    cfg_pa_width = 2'd2;
    capture(56'hAB_CDEF_0123_4567, 1'b1, 1'b1);
    read3(v);
    e = expw(56'hAB_CDEF_0123_4567, 1, 1, 2'd2, 6);
    check(v == e, "R2 R4 capture 56-bit", v, e);

    // R3: 48-bit width drops 55:48
    cfg_pa_width = 2'd0;
    capture(56'hFF_FFFF_FFFF_FFFF, 1'b0, 1'b1);
    read3(v);
    e = expw(56'hFF_FFFF_FFFF_FFFF, 0, 1, 2'd0, 6);
    check(v == e, "R3 capture 48-bit", v, e);

    // R3: 52-bit width drops 55:52
    cfg_pa_width = 2'd1;
    capture(56'hFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
    read3(v);
    e = expw(56'hFF_FFFF_FFFF_FFFF, 1, 0, 2'd1, 6);
    check(v == e, "R3 capture 52-bit", v, e);

    // R8 R3: permitted level-2 write, no alignment, 61:56 forced zero
    cfg_pa_width = 2'd2;
    access(2'd2, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    release_acc();
    read3(v);
    e = 64'hC0FF_FFFF_FFFF_FFFF;
    check(v == e, "R8 R3 level-2 write", v, e);

    // R9: denied level-1 write leaves register unchanged
    cfg_nv = 0;
    access(2'd1, 1'b1, 64'h1234_5678_9ABC_DEF0);
    check(undef == 1'b1, "R9 denied write flagged", undef, 1);
    release_acc();
    read3(v);
    check(v == e, "R9 denied write holds", v, e);

    // R9: denied read at level 0 returns zero
    access(2'd0, 1'b0, '0);
    check(rd_data == 64'h0, "R9 denied read zero", rd_data, 0);
    release_acc();

    // R7: trapped write from level 2 also holds
    cfg_el3_acc_en = 0;
    access(2'd2, 1'b1, 64'h0);
    check(trap && trap_el == 2'd3, "R7 trap to level 3", {trap, trap_el}, 3'b111);
    release_acc();
    cfg_el3_acc_en = 1;
    read3(v);
    check(v == e, "R9 trapped write holds", v, e);

    // R10: capture beats a same-cycle permitted write
    @(negedge clk);
    cap_valid = 1; cap_addr = 56'h00_0000_0000_1FFF; cap_ns = 0; cap_nse = 0;
    acc_valid = 1; acc_el = 2'd3; acc_write = 1; acc_wdata = 64'h8000_0000_0000_5555;
    @(posedge clk); #1;
    cap_valid = 0; acc_valid = 0; acc_write = 0;
    read3(v);
    e = expw(56'h00_0000_0000_1FFF, 0, 0, 2'd2, 6);
    check(v == e, "R10 capture wins", v, e);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule